// File: doc/BRIEF.md
# Colour LCD Controller Register Interface

This block is the programmer-visible register file of a colour LCD controller. It decodes a 32-bit, word-addressed bus. It holds four timing words, the base addresses of the upper and lower panels, an interrupt mask and a control word. It keeps a sticky interrupt status and exposes a window onto an external palette store. A small set of read-only identification bytes sits at the top of the map.

From the stored words it derives the visible screen width and height, a combined enable, and the pixel depth code. The pixel engine consumes these signals directly.

Event strobes from the pixel engine set the status bits. Software clears them by writing ones to a clear location, and a masked view drives a single interrupt line. Any write that alters the picture geometry, the control word or a palette entry produces a one-cycle redraw pulse. A downstream frame fetcher uses this pulse to refresh the whole screen.

Read data is registered. It appears, together with a valid strobe and an error strobe, on the cycle after the request.

Top module: `lcdc_regfile`

## Requirements
- R1: After reset every stored word, the status and the mask are zero, so `scr_width` is 16, `scr_height` is 1, and `lcd_on`, `irq`, `redraw` and `bus_err` are 0.
- R2: Word offsets 0–3 (timing), 4 (upper base), 5 (lower base) and 7 (control) store all 32 written bits and read them back. Offset 6 (mask) keeps only the low IRQ_W bits and reads them zero-extended. `bus_rvalid` and `bus_rdata` appear on the cycle after a read request.
- R3: `scr_width` equals (timing0 bits [7:2] + 1) × 16, and `scr_height` equals timing1 bits [9:0] + 1.
- R4: `lcd_on` is 1 only when control bit 0 and control bit 11 are both 1. `depth_mode` is control bits [3:1].
- R5: A 1 on any bit of `evt_in` sets the same status bit, which stays set until it is cleared. Offset 8 reads the status. A write to offset 8 changes nothing and is an error.
- R6: Offset 9 reads status AND mask. `irq` is the OR of the masked status bits.
- R7: Writing offset 10 clears each status bit whose written bit is 1. If an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R8: Offsets 11 and 12 read the upper and lower base addresses. Writes to them are ignored and flagged as errors.
- R9: Word offsets 128–255 (bytes 0x200–0x3FF) form the palette window. A write there asserts `pal_we` with `pal_idx` equal to offset − 128 and `pal_wdata` equal to the bus data, in the cycle of the request. A read there returns `pal_rdata` sampled at that index.
- R10: Word offsets 1016–1023 read the identification bytes 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in ascending offset order. Writes there are ignored and flagged as errors.
- R11: `redraw` pulses high for one cycle, one cycle after a write to a timing offset, the control offset or the palette window. No other write produces it.
- R12: Any access to an offset that is not mapped for that direction reads as zero and leaves all state unchanged. This covers reads of offset 10, writes to read-only locations, offsets 13–127 and offsets 256–1015. `bus_err` pulses high on the cycle after such an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Access to an unmapped offset, one cycle after request |
| evt_in | input | IRQ_W | Status set strobes |
| pal_we | output | 1 | Palette write strobe |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data at `pal_idx` |
| tmg0 | output | 32 | Timing word 0 |
| tmg1 | output | 32 | Timing word 1 |
| tmg2 | output | 32 | Timing word 2 |
| tmg3 | output | 32 | Timing word 3 |
| upper_base | output | 32 | Upper panel base address |
| lower_base | output | 32 | Lower panel base address |
| ctrl_word | output | 32 | Control word |
| scr_width | output | 11 | Screen width in pixels |
| scr_height | output | 11 | Screen height in lines |
| lcd_on | output | 1 | Enable and power both set |
| depth_mode | output | 3 | Pixel depth code |
| irq | output | 1 | Interrupt request |
| redraw | output | 1 | Full-redraw pulse |

## Verification
The bench covers the extremes of the packed geometry fields: width 16 and 1024, and height 1 and 1024, with unrelated high bits set in the timing words. A decoder that used the wrong slice, or left out the +1, would report a wrong size. It sets only one of the two enable bits at a time, where a design that OR-ed them would switch the panel on too early. It also clears a status bit while an event sets the same bit, where a design that let the clear win would lose the event. The bench then reads the palette and ID windows at both edges, writes to read-only and unmapped offsets, and reads the write-only clear offset. A decoder with a wrong range boundary would alias a register or fail to raise the error pulse. A write to the base registers must not produce the redraw pulse.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int PAL_W  = 7;
    localparam int DIM_W  = 11;

    typedef enum logic [3:0] {
        AR_TIM, AR_UPB, AR_LPB, AR_MSK, AR_CTL,
        AR_RIS, AR_MIS, AR_ICR, AR_UPC, AR_LPC,
        AR_PAL, AR_ID,  AR_NONE
    } region_e;

    typedef struct packed {
        region_e          kind;
        logic [1:0]       tidx;
        logic [PAL_W-1:0] pidx;
        logic [2:0]       iidx;
    } dec_t;

    function automatic logic [7:0] id_byte(input logic [2:0] i);
        case (i)
            3'd0:    return 8'h10;
            3'd1:    return 8'h11;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

    function automatic logic rd_legal(input region_e k);
        return (k != AR_NONE) && (k != AR_ICR);
    endfunction

    function automatic logic wr_legal(input region_e k);
        return (k == AR_TIM) || (k == AR_UPB) || (k == AR_LPB) ||
               (k == AR_MSK) || (k == AR_CTL) || (k == AR_ICR) ||
               (k == AR_PAL);
    endfunction

endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
    import lcdc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    always_comb begin
        dec.kind = AR_NONE;
        dec.tidx = addr[1:0];
        dec.pidx = addr[PAL_W-1:0];
        dec.iidx = addr[2:0];
        if (addr < ADDR_W'(13)) begin
            case (addr[3:0])
                4'd0, 4'd1, 4'd2, 4'd3: dec.kind = AR_TIM;
                4'd4:    dec.kind = AR_UPB;
                4'd5:    dec.kind = AR_LPB;
                4'd6:    dec.kind = AR_MSK;
                4'd7:    dec.kind = AR_CTL;
                4'd8:    dec.kind = AR_RIS;
                4'd9:    dec.kind = AR_MIS;
                4'd10:   dec.kind = AR_ICR;
                4'd11:   dec.kind = AR_UPC;
                default: dec.kind = AR_LPC;
            endcase
        end else if (addr[ADDR_W-1:PAL_W] == 3'b001) begin
            dec.kind = AR_PAL;
        end else if (addr[ADDR_W-1:3] == 7'h7F) begin
            dec.kind = AR_ID;
        end
    end
endmodule

// File: rtl/lcdc_irq.sv
module lcdc_irq #(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] evt,
    input  logic             msk_we,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] wbits,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] mask,
    output logic             irq
);
    logic [IRQ_W-1:0] clr_bits;

    assign clr_bits = clr_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= (raw & ~clr_bits) | evt;
            if (msk_we) mask <= wbits;
        end
    end

    assign irq = |(raw & mask);
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom
    import lcdc_pkg::*;
(
    input  logic [5:0]       hfield,
    input  logic [9:0]       vfield,
    input  logic             en_bit,
    input  logic             pwr_bit,
    input  logic [2:0]       depth_bits,
    output logic [DIM_W-1:0] width,
    output logic [DIM_W-1:0] height,
    output logic             on,
    output logic [2:0]       depth
);
    localparam int HSHIFT = 4;

    assign width  = (DIM_W'(hfield) + DIM_W'(1)) << HSHIFT;
    assign height = DIM_W'(vfield) + DIM_W'(1);
    assign on     = en_bit & pwr_bit;
    assign depth  = depth_bits;
endmodule

// File: rtl/lcdc_regfile.sv
module lcdc_regfile
    import lcdc_pkg::*;
#(
    parameter int IRQ_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_err,
    input  logic [IRQ_W-1:0]  evt_in,
    output logic              pal_we,
    output logic [PAL_W-1:0]  pal_idx,
    output logic [DATA_W-1:0] pal_wdata,
    input  logic [DATA_W-1:0] pal_rdata,
    output logic [DATA_W-1:0] tmg0,
    output logic [DATA_W-1:0] tmg1,
    output logic [DATA_W-1:0] tmg2,
    output logic [DATA_W-1:0] tmg3,
    output logic [DATA_W-1:0] upper_base,
    output logic [DATA_W-1:0] lower_base,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DIM_W-1:0]  scr_width,
    output logic [DIM_W-1:0]  scr_height,
    output logic              lcd_on,
    output logic [2:0]        depth_mode,
    output logic              irq,
    output logic              redraw
);
    localparam int NTIM = 4;
    localparam int ZPAD = DATA_W - IRQ_W;

    dec_t              dec;
    logic              wr_req, rd_req;
    logic [DATA_W-1:0] tim_q [NTIM];
    logic [DATA_W-1:0] upb_q, lpb_q, ctl_q;
    logic [IRQ_W-1:0]  raw_q, msk_q;
    logic [DATA_W-1:0] rd_mux;
    logic              bad_acc;

    lcdc_decode u_dec (.addr(bus_addr), .dec(dec));

    assign wr_req = bus_sel & bus_wr;
    assign rd_req = bus_sel & ~bus_wr;

    genvar gi;
    generate
        for (gi = 0; gi < NTIM; gi++) begin : g_tim
            always_ff @(posedge clk) begin
                if (rst) tim_q[gi] <= '0;
                else if (wr_req && dec.kind == AR_TIM && dec.tidx == 2'(gi))
                    tim_q[gi] <= bus_wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            upb_q <= '0;
            lpb_q <= '0;
            ctl_q <= '0;
        end else if (wr_req) begin
            if (dec.kind == AR_UPB) upb_q <= bus_wdata;
            if (dec.kind == AR_LPB) lpb_q <= bus_wdata;
            if (dec.kind == AR_CTL) ctl_q <= bus_wdata;
        end
    end

    lcdc_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_in),
        .msk_we (wr_req && dec.kind == AR_MSK),
        .clr_we (wr_req && dec.kind == AR_ICR),
        .wbits  (bus_wdata[IRQ_W-1:0]),
        .raw    (raw_q),
        .mask   (msk_q),
        .irq    (irq)
    );

    lcdc_geom u_geom (
        .hfield     (tim_q[0][7:2]),
        .vfield     (tim_q[1][9:0]),
        .en_bit     (ctl_q[0]),
        .pwr_bit    (ctl_q[11]),
        .depth_bits (ctl_q[3:1]),
        .width      (scr_width),
        .height     (scr_height),
        .on         (lcd_on),
        .depth      (depth_mode)
    );

    assign pal_we    = wr_req && dec.kind == AR_PAL;
    assign pal_idx   = dec.pidx;
    assign pal_wdata = bus_wdata;

    always_comb begin
        case (dec.kind)
            AR_TIM:  rd_mux = tim_q[dec.tidx];
            AR_UPB,
            AR_UPC:  rd_mux = upb_q;
            AR_LPB,
            AR_LPC:  rd_mux = lpb_q;
            AR_MSK:  rd_mux = {{ZPAD{1'b0}}, msk_q};
            AR_CTL:  rd_mux = ctl_q;
            AR_RIS:  rd_mux = {{ZPAD{1'b0}}, raw_q};
            AR_MIS:  rd_mux = {{ZPAD{1'b0}}, raw_q & msk_q};
            AR_PAL:  rd_mux = pal_rdata;
            AR_ID:   rd_mux = {24'd0, id_byte(dec.iidx)};
            default: rd_mux = '0;
        endcase
    end

    assign bad_acc = bus_sel & (bus_wr ? ~wr_legal(dec.kind) : ~rd_legal(dec.kind));

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            bus_err    <= 1'b0;
            redraw     <= 1'b0;
        end else begin
            bus_rdata  <= (rd_req && !bad_acc) ? rd_mux : '0;
            bus_rvalid <= rd_req;
            bus_err    <= bad_acc;
            redraw     <= wr_req && (dec.kind == AR_TIM || dec.kind == AR_CTL ||
                                     dec.kind == AR_PAL);
        end
    end

    assign tmg0       = tim_q[0];
    assign tmg1       = tim_q[1];
    assign tmg2       = tim_q[2];
    assign tmg3       = tim_q[3];
    assign upper_base = upb_q;
    assign lower_base = lpb_q;
    assign ctrl_word  = ctl_q;
endmodule

// File: rtl/lcdc_regfile_chk.sv
module lcdc_regfile_chk
    import lcdc_pkg::*;
#(
    parameter int IRQ_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rvalid,
    input logic              bus_err,
    input logic [IRQ_W-1:0]  evt_in,
    input logic [IRQ_W-1:0]  raw,
    input logic [IRQ_W-1:0]  mask,
    input logic [DATA_W-1:0] ctrl_word,
    input logic [DIM_W-1:0]  scr_width,
    input logic              lcd_on,
    input logic              irq,
    input logic              redraw
);
    assert_rvalid_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    assert_width_step_R3: assert property (@(posedge clk) disable iff (rst)
        (scr_width[3:0] == 4'd0) && (scr_width != '0));

    assert_on_needs_both_R4: assert property (@(posedge clk) disable iff (rst)
        lcd_on |-> (ctrl_word[0] && ctrl_word[11]));

    assert_event_sticks_R5: assert property (@(posedge clk) disable iff (rst)
        (evt_in != '0) |=> ((raw & $past(evt_in)) == $past(evt_in)));

    assert_irq_source_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((raw & mask) != '0));

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(10) && evt_in == '0)
        |=> ((raw & $past(bus_wdata[IRQ_W-1:0])) == '0));

    assert_redraw_cause_R11: assert property (@(posedge clk) disable iff (rst)
        redraw |-> $past(bus_sel && bus_wr));

    assert_err_cause_R12: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_sel));
endmodule

bind lcdc_regfile lcdc_regfile_chk #(.IRQ_W(IRQ_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .bus_err    (bus_err),
    .evt_in     (evt_in),
    .raw        (raw_q),
    .mask       (msk_q),
    .ctrl_word  (ctrl_word),
    .scr_width  (scr_width),
    .lcd_on     (lcd_on),
    .irq        (irq),
    .redraw     (redraw)
);

// File: tb/lcdc_regfile_bench.sv
module lcdc_regfile_bench;
    localparam int IRQ_W = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, bus_err;
    logic [IRQ_W-1:0] evt_in = '0;
    logic        pal_we;
    logic [6:0]  pal_idx;
    logic [31:0] pal_wdata, pal_rdata;
    logic [31:0] tmg0, tmg1, tmg2, tmg3, upper_base, lower_base, ctrl_word;
    logic [10:0] scr_width, scr_height;
    logic        lcd_on, irq, redraw;
    logic [2:0]  depth_mode;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] data;
        logic        err;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #4 clk = ~clk;

    assign pal_rdata = {16'hB0B0, 9'd0, pal_idx};

    lcdc_regfile #(.IRQ_W(IRQ_W)) u_lcdc_regfile (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected read items as results appear
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (sbq.size() == 0) begin
                check("R2 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                item_t it;
                it = sbq.pop_front();
                check(it.tag, bus_rdata, it.data);
                check({it.tag, " err"}, {31'd0, bus_err}, {31'd0, it.err});
            end
        end
    end

    task automatic rd(input int a, input logic [31:0] exp, input logic e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = 10'(a);
        it.data = exp; it.err = e; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    logic last_err, last_redraw, last_pwe;
    logic [6:0] last_pidx;

    task automatic wr(input int a, input logic [31:0] d, input logic [IRQ_W-1:0] ev);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = 10'(a); bus_wdata = d; evt_in = ev;
        #1;
        last_pwe = pal_we; last_pidx = pal_idx;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0; evt_in = '0;
        last_err = bus_err; last_redraw = redraw;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=<20000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #2;
        // R1 reset state
        check("R1 width", 32'(scr_width), 32'd16);
        check("R1 height", 32'(scr_height), 32'd1);
        check("R1 on/irq/redraw/err", {28'd0, lcd_on, irq, redraw, bus_err}, 32'd0);
        check("R1 ctrl", ctrl_word, 32'd0);
        rd(0, 32'd0, 0, "R1 timing0 read");
        rd(8, 32'd0, 0, "R1 status read");
        idle();

        // R3 geometry and R2 storage
        wr(0, 32'h0000_00FC, '0);
        check("R3 width max", 32'(scr_width), 32'd1024);
        check("R11 redraw timing", {31'd0, last_redraw}, 32'd1);
        wr(0, 32'h1234_5678, '0);
        check("R3 width mid", 32'(scr_width), 32'd496);
        wr(1, 32'hFFFF_FC00, '0);
        check("R3 height min", 32'(scr_height), 32'd1);
        wr(1, 32'h0000_03FF, '0);
        check("R3 height max", 32'(scr_height), 32'd1024);
        wr(1, 32'h0000_01DF, '0);
        check("R3 height 480", 32'(scr_height), 32'd480);
        wr(2, 32'hA5A5_0001, '0);
        wr(3, 32'h5A5A_0002, '0);
        wr(4, 32'h8000_1000, '0);
        check("R11 no redraw base", {31'd0, last_redraw}, 32'd0);
        wr(5, 32'h0000_2000, '0);
        rd(0, 32'h1234_5678, 0, "R2 timing0");
        rd(1, 32'h0000_01DF, 0, "R2 timing1");
        rd(2, 32'hA5A5_0001, 0, "R2 timing2");
        rd(3, 32'h5A5A_0002, 0, "R2 timing3");
        rd(4, 32'h8000_1000, 0, "R2 upper base");
        rd(5, 32'h0000_2000, 0, "R2 lower base");
        rd(11, 32'h8000_1000, 0, "R8 upper current");
        rd(12, 32'h0000_2000, 0, "R8 lower current");
        idle();
        wr(11, 32'hDEAD_BEEF, '0);
        check("R8 write current err", {31'd0, last_err}, 32'd1);
        check("R8 base unchanged", upper_base, 32'h8000_1000);

        // R4 enable
        wr(7, 32'h0000_0001, '0);
        check("R4 enable only", {31'd0, lcd_on}, 32'd0);
        check("R11 redraw ctrl", {31'd0, last_redraw}, 32'd1);
        wr(7, 32'h0000_0800, '0);
        check("R4 power only", {31'd0, lcd_on}, 32'd0);
        wr(7, 32'h0000_080B, '0);
        check("R4 both", {31'd0, lcd_on}, 32'd1);
        check("R4 depth", 32'(depth_mode), 32'd5);
        rd(7, 32'h0000_080B, 0, "R2 control");
        idle();

        // R5 R6 R7 status
        wr(6, 32'hFFFF_FFF5, '0);
        check("R11 no redraw mask", {31'd0, last_redraw}, 32'd0);
        rd(6, 32'h0000_0005, 0, "R2 mask");
        idle();
        @(posedge clk); #1 evt_in = 4'b0110;
        @(posedge clk); #1 evt_in = '0;
        #1;
        check("R6 irq set", {31'd0, irq}, 32'd1);
        rd(8, 32'h6, 0, "R5 status");
        rd(9, 32'h4, 0, "R6 masked");
        idle();
        wr(10, 32'h4, '0);
        check("R6 irq cleared", {31'd0, irq}, 32'd0);
        rd(8, 32'h2, 0, "R7 after clear");
        idle();
        wr(8, 32'hF, '0);
        check("R5 write status err", {31'd0, last_err}, 32'd1);
        rd(8, 32'h2, 0, "R5 status unchanged");
        idle();
        wr(10, 32'h2, 4'h2);
        rd(8, 32'h2, 0, "R7 set wins");
        idle();
        wr(10, 32'hF, '0);
        rd(8, 32'h0, 0, "R7 clear all");
        rd(10, 32'h0, 1, "R12 read clear reg");
        idle();

        // R9 palette
        wr(133, 32'h0000_CAFE, '0);
        check("R9 pal_we", {31'd0, last_pwe}, 32'd1);
        check("R9 pal_idx", 32'(last_pidx), 32'd5);
        check("R11 redraw palette", {31'd0, last_redraw}, 32'd1);
        rd(128, 32'hB0B0_0000, 0, "R9 palette first");
        rd(255, 32'hB0B0_007F, 0, "R9 palette last");
        // R10 ID bytes
        rd(1016, 32'h10, 0, "R10 id0");
        rd(1017, 32'h11, 0, "R10 id1");
        rd(1018, 32'h04, 0, "R10 id2");
        rd(1019, 32'h00, 0, "R10 id3");
        rd(1020, 32'h0D, 0, "R10 id4");
        rd(1021, 32'hF0, 0, "R10 id5");
        rd(1022, 32'h05, 0, "R10 id6");
        rd(1023, 32'hB1, 0, "R10 id7");
        // R12 unmapped
        rd(13, 32'h0, 1, "R12 read 13");
        rd(127, 32'h0, 1, "R12 read 127");
        rd(256, 32'h0, 1, "R12 read 256");
        rd(1015, 32'h0, 1, "R12 read 1015");
        idle();
        wr(1016, 32'hFFFF_FFFF, '0);
        check("R10 id write err", {31'd0, last_err}, 32'd1);
        wr(20, 32'hFFFF_FFFF, '0);
        check("R12 write err", {31'd0, last_err}, 32'd1);
        check("R12 no redraw", {31'd0, last_redraw}, 32'd0);
        check("R12 no pal_we", {31'd0, last_pwe}, 32'd0);
        rd(1016, 32'h10, 0, "R10 id after write");
        rd(2, 32'hA5A5_0001, 0, "R12 state unchanged");
        idle();
        repeat (3) @(posedge clk);
        check("R2 scoreboard drained", 32'(sbq.size()), 32'd0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule